// File: doc/BRIEF.md
# Battery Charge Mode Controller

This block is the decision core of a battery charger. Each clock it chooses between fast charge and trickle charge from a set of condition flags that other logic has already digitized: the pack voltage window, negative voltage-slope samples, charge-timer expiry, the two temperature limits, supply validity and a supply-rise strobe. Some causes of trickle only hold for as long as their condition lasts. Others are latched and stay in force until a fresh reset event.

A reset event is either the pack voltage entering its window or the supply-rise strobe. On a reset event the block drives a one-clock clear pulse to the external charge timer and clears its own latches: full charge, timer expiry and over-temperature. While the supply is invalid, the clear output is held high and every latch is held clear. The end-of-charge detector counts consecutive negative voltage-slope samples. Samples taken before the holdoff flag from the timer block goes high are not counted.

Top module: `charge_mode_ctrl`

## Requirements
- R1: After reset is released and before the first clock edge, `fast_o` and `clr_o` are both 0.
- R2: `fast_o` is registered. After a clock edge it is 1 only if, at that edge, `win_in` and `sup_ok` were 1, `tmr_done`, `temp_cold` and `temp_hot` were 0, and no latch was set after that edge.
- R3: A rise of `win_in` (1 at this edge, 0 at the previous edge) is a reset event. After that edge `clr_o` is 1 for exactly one cycle, provided the supply is valid.
- R4: When `win_in` falls, `fast_o` goes to 0 after the next edge, and no latch is set.
- R5: `temp_cold` keeps `fast_o` at 0 only while it is 1. Fast charge returns after the edge at which it is seen low, without any reset event.
- R6: `tmr_done` sets the timer latch. This keeps `fast_o` at 0 after `tmr_done` falls, until a reset event.
- R7: `temp_hot` sets the over-temperature latch. This keeps `fast_o` at 0 after `temp_hot` falls, until a reset event.
- R8: A sample is an edge with `dv_smp`=1, and it is counted when `dv_drop` and `hold_done` are also 1. `NDV_RUN` counted samples in a row set the full-charge latch, which forces trickle. A sample that is not counted restarts the run, and so does a reset event.
- R9: While `hold_done` is 0, samples with `dv_drop`=1 are not counted and do not affect `fast_o`.
- R10: While `sup_ok` is 0, `fast_o` is 0 and `clr_o` is 1, and every latch is cleared.
- R11: `sup_rise`=1 at an edge is a reset event. It pulses `clr_o` and clears the latches at that edge.
- R12: At the edge of a reset event, clearing takes priority over setting a latch. A limit condition seen at that same edge is therefore not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_in | input | 1 | Pack voltage is inside the fast-charge window |
| dv_smp | input | 1 | Voltage-slope sample strobe |
| dv_drop | input | 1 | The current sample shows a negative slope |
| hold_done | input | 1 | Slope-detection holdoff has elapsed |
| tmr_done | input | 1 | Charge timer has expired |
| temp_cold | input | 1 | Pack temperature is below the low limit |
| temp_hot | input | 1 | Pack temperature is above the high limit |
| sup_ok | input | 1 | Supply is above the undervoltage threshold |
| sup_rise | input | 1 | Strobe for the supply becoming valid |
| fast_o | output | 1 | 1 = fast charge, 0 = trickle |
| clr_o | output | 1 | Clear to the charge timer (one-clock pulse, or held during undervoltage) |

## Verification
A wrongly set or stuck latch shows up at `fast_o` one edge after its causing flag drops: fast charge fails to return, or returns without a reset event. A fault in the slope run counter shows up at the sample that should (or should not) complete the run, one cycle after that sample. Errors in reset-event detection show up on `clr_o` in the cycle after the window rise or supply strobe: either the pulse is missing, or it lasts more than one clock.

// File: rtl/charge_mode_ctrl.sv
module charge_mode_ctrl #(
  parameter int NDV_RUN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_in,
  input  logic dv_smp,
  input  logic dv_drop,
  input  logic hold_done,
  input  logic tmr_done,
  input  logic temp_cold,
  input  logic temp_hot,
  input  logic sup_ok,
  input  logic sup_rise,
  output logic fast_o,
  output logic clr_o
);
  localparam int CW = $clog2(NDV_RUN + 1);
  localparam logic [CW-1:0] LAST = CW'(NDV_RUN - 1);

  logic          win_q;
  logic [CW-1:0] run_q, run_d;
  logic          full_q, tmo_q, hot_q;
  logic          full_d, tmo_d, hot_d;
  logic          fast_d;

  wire entry   = win_in & ~win_q;
  wire rs_evt  = entry | sup_rise;
  wire wipe    = rs_evt | ~sup_ok;
  wire counted = dv_smp & dv_drop & hold_done;
  wire run_hit = counted & (run_q == LAST);

  always_comb begin
    if (wipe)
      run_d = '0;
    else if (dv_smp)
      run_d = (counted && !run_hit) ? run_q + 1'b1 : '0;
    else
      run_d = run_q;
  end

  assign full_d = ~wipe & (full_q | run_hit);
  assign tmo_d  = ~wipe & (tmo_q  | tmr_done);
  assign hot_d  = ~wipe & (hot_q  | temp_hot);

  assign fast_d = sup_ok & win_in & ~tmr_done & ~temp_cold & ~temp_hot
                & ~full_d & ~tmo_d & ~hot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      run_q  <= '0;
      full_q <= 1'b0;
      tmo_q  <= 1'b0;
      hot_q  <= 1'b0;
      fast_o <= 1'b0;
      clr_o  <= 1'b0;
    end else begin
      win_q  <= win_in;
      run_q  <= run_d;
      full_q <= full_d;
      tmo_q  <= tmo_d;
      hot_q  <= hot_d;
      fast_o <= fast_d;
      clr_o  <= rs_evt | ~sup_ok;
    end
  end
endmodule

module charge_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic win_in,
  input logic tmr_done,
  input logic temp_cold,
  input logic temp_hot,
  input logic sup_ok,
  input logic sup_rise,
  input logic fast_o,
  input logic clr_o
);
  logic win_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) win_d <= 1'b0;
    else        win_d <= win_in;

  p_uvlo_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> clr_o);
  p_uvlo_trickle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_ok |=> !fast_o);
  p_entry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_in && !win_d) |=> clr_o);
  p_block_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_in || tmr_done || temp_cold || temp_hot) |=> !fast_o);
  p_rise_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sup_rise |=> clr_o);
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_ok && !sup_rise && !(win_in && !win_d)) |=> !clr_o);
endmodule

bind charge_mode_ctrl charge_mode_ctrl_chk u_chk (.*);

// File: tb/sim_charge_mode_ctrl.sv
module sim_charge_mode_ctrl;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic win = 0, dvs = 0, dvd = 0, hold = 0, tmr = 0, cold = 0, hot = 0;
  logic sok = 1, srise = 0;
  logic fast, clr;

  int checks = 0, fails = 0;
  bit qf[$];
  bit qc[$];
  string qt[$];

  always #(PERIOD/2) clk = ~clk;

  charge_mode_ctrl #(.NDV_RUN(2)) u0 (
    .clk(clk), .rst_n(rst_n), .win_in(win), .dv_smp(dvs), .dv_drop(dvd),
    .hold_done(hold), .tmr_done(tmr), .temp_cold(cold), .temp_hot(hot),
    .sup_ok(sok), .sup_rise(srise), .fast_o(fast), .clr_o(clr));

  task automatic check(input bit af, ac, ef, ec, input string tag);
    checks++;
    if (af !== ef || ac !== ec) begin
      fails++;
      $display("FAIL %s: fast/clr got %0b/%0b expected %0b/%0b", tag, af, ac, ef, ec);
    end
  endtask

  task automatic step(input bit ef, ec, input string tag);
    qf.push_back(ef); qc.push_back(ec); qt.push_back(tag);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && qf.size() > 0)
      check(fast, clr, qf.pop_front(), qc.pop_front(), qt.pop_front());
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(fast, clr, 1'b0, 1'b0, "R1 reset state");
    // R3 window entry pulse
    win = 1; step(1, 1, "R3 entry");
    step(1, 0, "R3 pulse one cycle");
    // R5 cold holds trickle, not latched
    cold = 1; step(0, 0, "R5 cold");
    cold = 0; step(1, 0, "R5 resume");
    // R4 window exit
    win = 0; step(0, 0, "R4 exit");
    win = 1; step(1, 1, "R4 re-entry");
    step(1, 0, "R2 steady fast");
    // R6 timer latch, cleared by R11 supply rise
    tmr = 1; step(0, 0, "R6 expiry");
    tmr = 0; step(0, 0, "R6 latched");
    step(0, 0, "R6 still latched");
    srise = 1; step(1, 1, "R11 rise clears");
    srise = 0; step(1, 0, "R11 single pulse");
    // R7 over-temperature latch
    hot = 1; step(0, 0, "R7 hot");
    hot = 0; step(0, 0, "R7 latched");
    win = 0; step(0, 0, "R7 exit");
    win = 1; step(1, 1, "R7 cleared by entry");
    step(1, 0, "R7 fast back");
    // R9 events before holdoff do not count
    hold = 0; dvs = 1; dvd = 1;
    step(1, 0, "R9 early event 1");
    step(1, 0, "R9 early event 2");
    dvs = 0; dvd = 0; step(1, 0, "R9 no latch");
    // R8 consecutive counted events
    hold = 1;
    dvs = 1; dvd = 1; step(1, 0, "R8 first event");
    dvd = 0;          step(1, 0, "R8 break sample");
    dvd = 1;          step(1, 0, "R8 run restarted");
    step(0, 0, "R8 full latch set");
    dvs = 0; dvd = 0; step(0, 0, "R8 full latched");
    srise = 1; step(1, 1, "R8 cleared");
    srise = 0;
    dvs = 1; dvd = 1; step(1, 0, "R8 event before pulse");
    dvs = 0; dvd = 0; srise = 1; step(1, 1, "R8 pulse");
    srise = 0; dvs = 1; dvd = 1; step(1, 0, "R8 run cleared by pulse");
    dvs = 0; dvd = 0; step(1, 0, "R8 idle");
    // R12 clear beats set
    win = 0; step(0, 0, "R12 exit");
    win = 1; hot = 1; step(0, 1, "R12 entry with hot");
    hot = 0; step(1, 0, "R12 hot not latched");
    // R10 undervoltage
    tmr = 1; step(0, 0, "R10 timer latch");
    tmr = 0; step(0, 0, "R10 latched");
    sok = 0; step(0, 1, "R10 uvlo");
    step(0, 1, "R10 uvlo held");
    sok = 1; step(1, 0, "R10 latch wiped");
    step(1, 0, "R10 no pulse");
    @(negedge clk);
    finish_run();
  end
endmodule